// File: doc/BRIEF.md
# Threshold Crossing Trigger Detector

This block watches a stream of 8-bit samples and reports when the signal they describe crosses a programmable level or sits exactly on it. The level is written from a shared byte-wide data bus with a load strobe and held in a register. Each sample that arrives with its valid strobe is compared in magnitude with the held level. The block keeps the result of the previous comparison, so it can tell an upward crossing from a downward one.

Three registered event outputs report an upward crossing, a downward crossing and an exact match. The match event is meant for slowly moving signals that might step onto the level without ever going past it. A 2-bit mode input picks which event sets a sticky trigger flag for the acquisition sequencer. The flag stays high until the sequencer pulses `arm`. Reloading the level, or resetting the block, discards the comparison history, so no edge can be inferred from a sample that was compared with an old level.

Top module: `thr_trigger_detector`

## Requirements
- R1: During and after reset, with no sample yet taken, `edgeRise`, `edgeFall`, `levelMatch` and `trigFlag` are 0, and the held level is 0.
- R2: When `levelLoad` is high on a clock edge, `busData` becomes the held level. A sample presented in the same cycle is ignored: it produces no event and does not update the comparison history.
- R3: `edgeRise` is high for the one cycle after a valid sample that is greater than or equal to the level, when the previous valid sample was strictly below the level.
- R4: `edgeFall` is high for the one cycle after a valid sample that is less than or equal to the level, when the previous valid sample was strictly above the level.
- R5: `levelMatch` is high for the one cycle after any valid sample equal to the level, whatever the history, including the first sample.
- R6: The first valid sample after reset, and the first after a level load, only records history and cannot raise `edgeRise` or `edgeFall`.
- R7: Cycles without `sampleValid` raise no event and leave the history unchanged, so a crossing that spans a gap of idle cycles is still reported.
- R8: `modeSel` picks the flag source: 2'b00 upward crossing, 2'b01 downward crossing, 2'b10 match, 2'b11 either crossing. `trigFlag` rises in the same cycle as the selected event output.
- R9: `trigFlag` stays high until `arm` is sampled high. It is 0 in the cycle after `arm`, even if a selected event occurs in the arm cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Qualifies `sampleData` in this cycle |
| sampleData | input | 8 | Sample to compare with the level |
| levelLoad | input | 1 | Loads `busData` into the level register |
| busData | input | 8 | Shared data bus byte carrying the new level |
| modeSel | input | 2 | Selects the event that sets `trigFlag` |
| arm | input | 1 | Clears `trigFlag` |
| edgeRise | output | 1 | Upward crossing event, one cycle |
| edgeFall | output | 1 | Downward crossing event, one cycle |
| levelMatch | output | 1 | Equality event, one cycle |
| trigFlag | output | 1 | Sticky selected-trigger flag |

## Verification
The only hidden state is the held level and the one-sample comparison history. A wrong level shows at `levelMatch`, or as a missing or extra crossing, on the first valid sample after the load. A history that is not cleared on reload or reset, or that is wrongly updated on idle or load cycles, shows as an edge event one cycle after the next valid sample. The stimulus therefore places samples exactly on the level, at both ends of the byte range, across idle gaps, and directly after reload and reset. A flag that fails to hold or fails to clear shows in the cycle after `arm`, or in any cycle after it was set.

// File: rtl/thr_pkg.sv
package thr_pkg;

  typedef enum logic [1:0] {
    MODE_RISE     = 2'b00,
    MODE_FALL     = 2'b01,
    MODE_EQUAL    = 2'b10,
    MODE_ANY_EDGE = 2'b11
  } trigMode_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadLevel;
    logic takeSample;
  } ctrlStrobe_t;

  // Event bundle from datapath
  typedef struct packed {
    logic rise;
    logic fall;
    logic equal;
  } trigEvt_t;

endpackage

// File: rtl/thr_magcmp.sv
module thr_magcmp #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] aVal,
  input  logic [DATA_W-1:0] bVal,
  output logic              aLess,
  output logic              aGreater,
  output logic              aEqual
);

  // Unsigned magnitude compare of a sample (a) against the level (b)
  always_comb begin
    aLess    = (aVal < bVal);
    aGreater = (aVal > bVal);
    aEqual   = (aVal == bVal);
  end

  always_comb begin
    assert_cmp_exclusive_R3: assert ($countones({aLess, aGreater, aEqual}) == 1);
  end

endmodule

// File: rtl/thr_datapath.sv
module thr_datapath
  import thr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [DATA_W-1:0] sampleData,
  input  logic [DATA_W-1:0] busData,
  output trigEvt_t          evtNow,
  output trigEvt_t          evtQ
);

  logic [DATA_W-1:0] levelQ;
  logic              histValid;
  logic              histBelow;
  logic              histAbove;
  logic              curLess;
  logic              curGreater;
  logic              curEqual;

  thr_magcmp #(.DATA_W(DATA_W)) u_cmp (
    .aVal    (sampleData),
    .bVal    (levelQ),
    .aLess   (curLess),
    .aGreater(curGreater),
    .aEqual  (curEqual)
  );

  // Level register: loaded from the shared bus
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelQ <= '0;
    else if (strobe.loadLevel) levelQ <= busData;
  end

  // Comparison history of the last accepted sample
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      histValid <= 1'b0;
      histBelow <= 1'b0;
      histAbove <= 1'b0;
    end else if (strobe.loadLevel) begin
      histValid <= 1'b0;
      histBelow <= 1'b0;
      histAbove <= 1'b0;
    end else if (strobe.takeSample) begin
      histValid <= 1'b1;
      histBelow <= curLess;
      histAbove <= curGreater;
    end
  end

  always_comb begin
    evtNow.rise  = strobe.takeSample & histValid & histBelow & ~curLess;
    evtNow.fall  = strobe.takeSample & histValid & histAbove & ~curGreater;
    evtNow.equal = strobe.takeSample & curEqual;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtQ <= '0;
    else       evtQ <= evtNow;
  end

  // A load cycle yields no events and takes the bus byte
  assert_load_ignores_sample_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadLevel |=> (evtQ == '0) && (levelQ == $past(busData)));

  // An idle cycle yields no events and keeps history
  assert_idle_no_event_R7: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.takeSample && !strobe.loadLevel |=>
      (evtQ == '0) && $stable(histBelow) && $stable(histAbove) && $stable(histValid));

  // A reported match refers to the sample and the level in the previous cycle
  assert_match_equal_R5: assert property (@(posedge clk) disable iff (!rstN)
    evtQ.equal |-> $past(sampleData) == $past(levelQ));

  // The crossings exclude each other
  assert_edges_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(evtQ.rise && evtQ.fall));

  // The first sample after a reload cannot make an edge
  assert_first_no_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    !histValid |=> !evtQ.rise && !evtQ.fall);

endmodule

// File: rtl/thr_control.sv
module thr_control
  import thr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic        levelLoad,
  input  logic        arm,
  input  logic [1:0]  modeSel,
  input  trigEvt_t    evtNow,
  output ctrlStrobe_t strobe,
  output logic        trigFlag
);

  trigMode_t modeQ;
  logic      selHit;

  always_comb begin
    modeQ             = trigMode_t'(modeSel);
    strobe.loadLevel  = levelLoad;
    strobe.takeSample = sampleValid & ~levelLoad;
  end

  always_comb begin
    unique case (modeQ)
      MODE_RISE:     selHit = evtNow.rise;
      MODE_FALL:     selHit = evtNow.fall;
      MODE_EQUAL:    selHit = evtNow.equal;
      MODE_ANY_EDGE: selHit = evtNow.rise | evtNow.fall;
      default:       selHit = 1'b0;
    endcase
  end

  // Sticky flag; arm wins over a simultaneous hit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       trigFlag <= 1'b0;
    else if (arm)    trigFlag <= 1'b0;
    else if (selHit) trigFlag <= 1'b1;
  end

  assert_arm_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> !trigFlag);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    trigFlag && !arm |=> trigFlag);

  assert_flag_needs_hit_R8: assert property (@(posedge clk) disable iff (!rstN)
    !trigFlag && !(selHit && !arm) |=> !trigFlag);

  assert_rise_sets_flag_R8: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b00) && evtNow.rise && !arm |=> trigFlag);

endmodule

// File: rtl/thr_trigger_detector.sv
module thr_trigger_detector
  import thr_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleData,
  input  logic              levelLoad,
  input  logic [DATA_W-1:0] busData,
  input  logic [1:0]        modeSel,
  input  logic              arm,
  output logic              edgeRise,
  output logic              edgeFall,
  output logic              levelMatch,
  output logic              trigFlag
);

  ctrlStrobe_t strobe;
  trigEvt_t    evtNow;
  trigEvt_t    evtQ;

  thr_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .levelLoad  (levelLoad),
    .arm        (arm),
    .modeSel    (modeSel),
    .evtNow     (evtNow),
    .strobe     (strobe),
    .trigFlag   (trigFlag)
  );

  thr_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .sampleData(sampleData),
    .busData   (busData),
    .evtNow    (evtNow),
    .evtQ      (evtQ)
  );

  assign edgeRise   = evtQ.rise;
  assign edgeFall   = evtQ.fall;
  assign levelMatch = evtQ.equal;

  // Outputs are quiet in the first cycle after reset
  assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !edgeRise && !edgeFall && !levelMatch && !trigFlag);

endmodule

// File: tb/tb_thr_trigger_detector.sv
module tb_thr_trigger_detector;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleValid = 1'b0;
  logic [7:0] sampleData = '0;
  logic       levelLoad = 1'b0;
  logic [7:0] busData = '0;
  logic [1:0] modeSel = 2'b00;
  logic       arm = 1'b0;
  logic       edgeRise, edgeFall, levelMatch, trigFlag;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  thr_trigger_detector dut (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleData(sampleData),
    .levelLoad(levelLoad), .busData(busData), .modeSel(modeSel), .arm(arm),
    .edgeRise(edgeRise), .edgeFall(edgeFall), .levelMatch(levelMatch), .trigFlag(trigFlag)
  );

  typedef struct packed {
    logic       ld;
    logic [7:0] bus;
    logic       vld;
    logic [7:0] smp;
    logic [1:0] mode;
    logic       armIn;
    logic       xRise;
    logic       xFall;
    logic       xMatch;
    logic       xFlag;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'h80, 1'b0, 8'h00, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R2 load level 0x80
    '{1'b0, 8'h00, 1'b1, 8'h10, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 first sample, below
    '{1'b0, 8'h00, 1'b1, 8'h90, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R3 rise, R8 flag
    '{1'b0, 8'h00, 1'b1, 8'h80, 2'b00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R4 fall onto level, R5
    '{1'b0, 8'h00, 1'b0, 8'h00, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 arm clears
    '{1'b0, 8'h00, 1'b1, 8'h7F, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // from equal to below
    '{1'b0, 8'h00, 1'b0, 8'h80, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R7 idle, data ignored
    '{1'b0, 8'h00, 1'b1, 8'h80, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R7 rise across gap
    '{1'b0, 8'h00, 1'b1, 8'h81, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // from equal: no edge, arm
    '{1'b0, 8'h00, 1'b1, 8'h20, 2'b01, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}, // R8 fall mode
    '{1'b1, 8'h20, 1'b1, 8'h20, 2'b01, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1}, // R2 sample ignored on load
    '{1'b0, 8'h00, 1'b0, 8'h00, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 arm
    '{1'b0, 8'h00, 1'b1, 8'hFF, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R6 first after reload
    '{1'b0, 8'h00, 1'b1, 8'h20, 2'b10, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R8 equal mode
    '{1'b0, 8'h00, 1'b1, 8'h20, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0}, // R9 arm beats hit
    '{1'b0, 8'h00, 1'b1, 8'h00, 2'b11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // any-edge mode, none
    '{1'b0, 8'h00, 1'b1, 8'h21, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1}, // R8 any-edge rise
    '{1'b0, 8'h00, 1'b0, 8'h00, 2'b11, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0}, // R9 arm
    '{1'b0, 8'h00, 1'b1, 8'h00, 2'b11, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1}  // R8 any-edge fall
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Drive at the falling edge, sample 1 ns after the rising edge
  task automatic step(input logic ld, input logic [7:0] bus, input logic vld,
                      input logic [7:0] smp, input logic [1:0] mode, input logic armIn);
    @(negedge clk);
    levelLoad = ld; busData = bus; sampleValid = vld; sampleData = smp;
    modeSel = mode; arm = armIn;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      nFails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "edgeRise in reset", edgeRise, 1'b0);
    chk("R1", "trigFlag in reset", trigFlag, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    chk("R1", "edgeFall after reset", edgeFall, 1'b0);
    chk("R1", "levelMatch after reset", levelMatch, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].ld, VECS[i].bus, VECS[i].vld, VECS[i].smp, VECS[i].mode, VECS[i].armIn);
      chk("R3", $sformatf("vec %0d edgeRise", i), edgeRise, VECS[i].xRise);
      chk("R4", $sformatf("vec %0d edgeFall", i), edgeFall, VECS[i].xFall);
      chk("R5", $sformatf("vec %0d levelMatch", i), levelMatch, VECS[i].xMatch);
      chk("R8", $sformatf("vec %0d trigFlag", i), trigFlag, VECS[i].xFlag);
    end

    // R6 and R1: history is discarded by reset, the level returns to 0
    step(1'b1, 8'h50, 1'b0, 8'h00, 2'b01, 1'b1);
    step(1'b0, 8'h00, 1'b1, 8'hF0, 2'b01, 1'b0);
    @(negedge clk);
    rstN = 1'b0; sampleValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 8'h00, 1'b1, 8'h00, 2'b01, 1'b0);
    chk("R6", "no fall after reset", edgeFall, 1'b0);
    chk("R1", "level is 0 after reset", levelMatch, 1'b1);
    chk("R6", "flag after reset", trigFlag, 1'b0);

    // R3, R5 at the top of the range
    step(1'b1, 8'hFF, 1'b0, 8'h00, 2'b00, 1'b0);
    step(1'b0, 8'h00, 1'b1, 8'h00, 2'b00, 1'b0);
    step(1'b0, 8'h00, 1'b1, 8'hFF, 2'b00, 1'b0);
    chk("R3", "rise onto 0xFF", edgeRise, 1'b1);
    chk("R5", "match at 0xFF", levelMatch, 1'b1);
    chk("R8", "flag on rise at 0xFF", trigFlag, 1'b1);
    step(1'b0, 8'h00, 1'b0, 8'h00, 2'b00, 1'b0);
    chk("R3", "rise lasts one cycle", edgeRise, 1'b0);
    chk("R9", "flag holds without arm", trigFlag, 1'b1);

    finished = 1'b1;
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule